// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM with Pipelined Deselect

This block is a synchronous static RAM with a small on-chip array and byte-lane writes. By default the array holds 1024 words of two 9-bit lanes. Every control and data input is captured on the rising clock edge, and all controls are active low.

An access starts when either of two start strobes is asserted while chip enable is low. That cycle loads the external address into a burst register. On the following cycles, the advance input steps an internal 2-bit beat counter. The counter forms the two low address bits in linear order (count up modulo 4) or in interleaved order (start XOR beat). The burst function is optional: a fresh start can be issued on every cycle.

A mode pin selects where read data appears. In flow-through mode it appears one edge after the access edge. In registered mode it appears two edges after. A deselect travels through the same pipeline as a read. Its effect on the data bus is held for a full cycle, so the bus turns off after the second edge that follows the deselect. The asynchronous output enable acts as the final gate. The tristate bus is modelled as `rdata_o` plus a drive flag `rvalid_o`, and the data reads zero whenever it is not driven.

Top module: `burst_sram`

## Requirements
- R1: A start strobe (`start_proc_n` or `start_ctrl_n` low) with `ce_n` low loads `addr_i`, and the first beat of the access uses exactly that address.
- R2: With `order_ilv_i` = 0, the burst's low two address bits are (start + beat) mod 4 and the upper bits stay fixed. Beat 4 wraps back to the start address.
- R3: With `order_ilv_i` = 1, the low two address bits are start XOR (beat mod 4).
- R4: `advance_n` has no effect in a cycle with a start strobe. In a later cycle with no strobe and `advance_n` high, the same address is accessed again.
- R5: With `reg_out_i` = 0 (flow-through), data of a read sampled at edge k is driven after edge k+1 and not before.
- R6: With `reg_out_i` = 1 (registered), data of a read sampled at edge k is driven after edge k+2 and not after edge k+1.
- R7: A deselect (a start strobe with `ce_n` high) sampled at edge k turns the bus off after edge k+2. In flow-through mode, the previous read data stays driven through edge k+1.
- R8: With `all_we_n` low, every lane is written, whatever `lane_mode_n` and `lane_we_n` hold.
- R9: With `all_we_n` high and `lane_mode_n` low, exactly the lanes whose `lane_we_n` bit is low are written. Bit i covers `wdata_i[9*i+8:9*i]`. With no lane selected, the cycle is a read.
- R10: `start_proc_n` low with `ce_n` low always starts a read, even when write controls are asserted.
- R11: Starts on consecutive cycles deliver one word per cycle with no gap.
- R12: `out_en_n` high forces `rvalid_o` low and `rdata_o` to zero at once, without waiting for a clock edge.
- R13: After reset the bus is off and no burst is active, so cycles without a strobe leave it off.
- R14: In flow-through mode, a write sampled at edge k turns the bus off after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| start_proc_n | input | 1 | Start strobe that forces a read |
| start_ctrl_n | input | 1 | Start strobe that honours the write controls |
| advance_n | input | 1 | Step the burst beat counter |
| addr_i | input | 10 | Word address |
| wdata_i | input | 18 | Write data, two 9-bit lanes |
| all_we_n | input | 1 | Write all lanes |
| lane_mode_n | input | 1 | Enable per-lane writes |
| lane_we_n | input | 2 | Per-lane write enables |
| reg_out_i | input | 1 | 1 = registered output, 0 = flow-through |
| order_ilv_i | input | 1 | 1 = interleaved burst order, 0 = linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 18 | Read data, zero when not driven |
| rvalid_o | output | 1 | Data bus is being driven |

## Verification
The hardest situation to reach is the one-cycle deselect hold in flow-through mode. The bus must keep showing the old read data for a full cycle after a deselect, and then turn off. This happens only when a read is followed directly by a deselect. The bench therefore issues a read and a deselect back to back and samples on each of the next three edges. It repeats this in registered mode, where the same deselect lines up with the read latency. Burst wrap and hold are reached by running five beats from a non-zero start, and by inserting a no-advance cycle into a burst.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Operation applied to the array in the cycle after sampling
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits for a beat: XOR for interleaved, modulo add for linear
  function automatic logic [1:0] beat_bits(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/sbr_burst_ctl.sv
module sbr_burst_ctl #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              start_proc_n,
  input  logic              start_ctrl_n,
  input  logic              advance_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              all_we_n,
  input  logic              lane_mode_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              order_ilv_i,
  output sbr_pkg::op_e      op_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  wmask_o,
  output logic [DATA_W-1:0] wdata_o
);
  import sbr_pkg::*;

  localparam int BEAT_W = 2;

  logic              strobe, selected;
  logic [LANES-1:0]  mask_req;
  logic              burst_on;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;
  op_e               op_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] wdata_q;

  assign strobe   = ~start_proc_n | ~start_ctrl_n;
  assign selected = ~ce_n;

  // Lane write request from the write controls
  always_comb begin
    if (!all_we_n)         mask_req = '1;
    else if (!lane_mode_n) mask_req = ~lane_we_n;
    else                   mask_req = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      op_q     <= OP_IDLE;
      mask_q   <= '0;
    end else if (strobe) begin
      if (selected) begin
        base_q   <= addr_i;
        beat_q   <= '0;
        burst_on <= 1'b1;
        if (!start_proc_n) begin
          op_q   <= OP_READ;
          mask_q <= '0;
        end else begin
          op_q   <= (|mask_req) ? OP_WRITE : OP_READ;
          mask_q <= mask_req;
        end
      end else begin
        burst_on <= 1'b0;
        op_q     <= OP_IDLE;
        mask_q   <= '0;
      end
    end else if (burst_on) begin
      if (!advance_n) beat_q <= beat_q + BEAT_W'(1);
      op_q   <= (|mask_req) ? OP_WRITE : OP_READ;
      mask_q <= mask_req;
    end else begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end
  end

  always_ff @(posedge clk) wdata_q <= wdata_i;

  assign op_o       = op_q;
  assign wmask_o    = mask_q;
  assign wdata_o    = wdata_q;
  assign acc_addr_o = {base_q[ADDR_W-1:BEAT_W],
                       beat_bits(base_q[BEAT_W-1:0], beat_q, order_ilv_i)};

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wmask[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) q <= mem[addr];
    end

    assign rdata[l*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/sbr_out_stage.sv
module sbr_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  sbr_pkg::op_e      op_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              reg_out_i,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  import sbr_pkg::*;

  logic              flow_v, prev_idle;
  logic              s1_rd, pipe_v;
  logic [DATA_W-1:0] pipe_q;
  logic              drive;

  // Flow-through drive flag: a deselect only takes effect after a second idle slot
  always_ff @(posedge clk) begin
    if (rst) begin
      flow_v    <= 1'b0;
      prev_idle <= 1'b1;
    end else begin
      prev_idle <= (op_i == OP_IDLE);
      unique case (op_i)
        OP_READ:  flow_v <= 1'b1;
        OP_WRITE: flow_v <= 1'b0;
        default:  if (prev_idle) flow_v <= 1'b0;
      endcase
    end
  end

  // Registered path: one more stage after the array read register
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd  <= 1'b0;
      pipe_v <= 1'b0;
    end else begin
      s1_rd  <= (op_i == OP_READ);
      pipe_v <= s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_rd) pipe_q <= rd_data_i;
  end

  assign drive    = ~out_en_n & (reg_out_i ? pipe_v : flow_v);
  assign rvalid_o = drive;
  assign rdata_o  = drive ? (reg_out_i ? pipe_q : rd_data_i) : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              start_proc_n,
  input  logic              start_ctrl_n,
  input  logic              advance_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              all_we_n,
  input  logic              lane_mode_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              reg_out_i,
  input  logic              order_ilv_i,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  import sbr_pkg::*;

  op_e               op;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  wmask;
  logic [DATA_W-1:0] wdata_s;
  logic [DATA_W-1:0] arr_q;

  sbr_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .ce_n(ce_n),
    .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n),
    .advance_n(advance_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .all_we_n(all_we_n), .lane_mode_n(lane_mode_n), .lane_we_n(lane_we_n),
    .order_ilv_i(order_ilv_i),
    .op_o(op), .acc_addr_o(acc_addr), .wmask_o(wmask), .wdata_o(wdata_s)
  );

  sbr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk),
    .rd_en(op == OP_READ),
    .wr_en(op == OP_WRITE),
    .wmask(wmask), .addr(acc_addr), .wdata(wdata_s), .rdata(arr_q)
  );

  sbr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .op_i(op), .rd_data_i(arr_q),
    .reg_out_i(reg_out_i), .out_en_n(out_en_n),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              start_proc_n,
  input logic              start_ctrl_n,
  input logic              all_we_n,
  input logic              reg_out_i,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  logic rd_start, desel, wr_all;
  assign rd_start = ~start_proc_n & ~ce_n;
  assign desel    = (~start_proc_n | ~start_ctrl_n) & ce_n;
  assign wr_all   = ~start_ctrl_n & start_proc_n & ~ce_n & ~all_we_n;

  assert_reset_off_R13: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid_o);

  assert_oe_gates_bus_R12: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!rvalid_o && rdata_o == '0));

  assert_flow_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (!reg_out_i && !out_en_n && $past(rd_start, 2) && !$past(rst) && !$past(rst, 2))
      |-> rvalid_o);

  assert_pipe_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_out_i && !out_en_n && $past(rd_start, 3) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> rvalid_o);

  assert_deselect_off_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(desel, 2) && $past(desel, 3)) |-> !rvalid_o);

  assert_write_slot_off_R14: assert property (@(posedge clk) disable iff (rst)
    (!reg_out_i && $past(wr_all, 2)) |-> !rvalid_o);

endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .start_proc_n(start_proc_n),
  .start_ctrl_n(start_ctrl_n), .all_we_n(all_we_n), .reg_out_i(reg_out_i),
  .out_en_n(out_en_n), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ce_n, start_proc_n, start_ctrl_n, advance_n;
  logic [9:0]  addr_i;
  logic [17:0] wdata_i;
  logic        all_we_n, lane_mode_n;
  logic [1:0]  lane_we_n;
  logic        reg_out_i, order_ilv_i, out_en_n;
  logic [17:0] rdata_o;
  logic        rvalid_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .start_proc_n(start_proc_n),
    .start_ctrl_n(start_ctrl_n), .advance_n(advance_n), .addr_i(addr_i),
    .wdata_i(wdata_i), .all_we_n(all_we_n), .lane_mode_n(lane_mode_n),
    .lane_we_n(lane_we_n), .reg_out_i(reg_out_i), .order_ilv_i(order_ilv_i),
    .out_en_n(out_en_n), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  typedef struct packed {
    logic [9:0]  a;
    logic [17:0] d;
    logic        gw_n;
    logic        lm_n;
    logic [1:0]  ln_n;
    logic        proc;
    logic [17:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{10'h010, 18'h2A5A5, 1'b0, 1'b1, 2'b11, 1'b0, 18'h2A5A5}, // R8 all lanes
    '{10'h010, 18'h00111, 1'b1, 1'b0, 2'b10, 1'b0, 18'h2A511}, // R9 lane 0 only
    '{10'h010, 18'h3FE00, 1'b1, 1'b0, 2'b01, 1'b0, 18'h3FF11}, // R9 lane 1 only
    '{10'h3FF, 18'h0F0F0, 1'b0, 1'b0, 2'b11, 1'b0, 18'h0F0F0}, // R8 overrides lane controls
    '{10'h3FF, 18'h3FFFF, 1'b1, 1'b1, 2'b00, 1'b0, 18'h0F0F0}, // R9 lane mode off: read
    '{10'h000, 18'h00001, 1'b0, 1'b1, 2'b11, 1'b0, 18'h00001}, // R1 lowest address
    '{10'h200, 18'h15555, 1'b1, 1'b0, 2'b00, 1'b0, 18'h15555}, // R9 both lanes
    '{10'h200, 18'h3FFFF, 1'b0, 1'b1, 2'b11, 1'b1, 18'h15555}  // R10 forced read
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_idle();
    ce_n = 1'b1; start_ctrl_n = 1'b0; start_proc_n = 1'b1; advance_n = 1'b1;
    all_we_n = 1'b1; lane_mode_n = 1'b1; lane_we_n = 2'b11;
  endtask

  task automatic drive_read(input logic [9:0] a);
    ce_n = 1'b0; start_proc_n = 1'b0; start_ctrl_n = 1'b1; advance_n = 1'b0;
    all_we_n = 1'b1; lane_mode_n = 1'b1; lane_we_n = 2'b11; addr_i = a;
  endtask

  task automatic drive_cont(input logic adv_n);
    ce_n = 1'b0; start_proc_n = 1'b1; start_ctrl_n = 1'b1; advance_n = adv_n;
    all_we_n = 1'b1; lane_mode_n = 1'b1; lane_we_n = 2'b11;
  endtask

  task automatic drive_write(input logic [9:0] a, input logic [17:0] d);
    ce_n = 1'b0; start_ctrl_n = 1'b0; start_proc_n = 1'b1; advance_n = 1'b1;
    all_we_n = 1'b0; lane_mode_n = 1'b1; lane_we_n = 2'b11; addr_i = a; wdata_i = d;
  endtask

  task automatic chk(input string tag, input logic ev, input logic [17:0] ed);
    logic [17:0] want;
    want = ev ? ed : 18'h0;
    tests++;
    if (rvalid_o !== ev || rdata_o !== want) begin
      fails++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               tag, rvalid_o, rdata_o, ev, want);
    end
  endtask

  task automatic rd_check(input logic [9:0] a, input logic [17:0] e, input string tag);
    drive_read(a); tick();
    set_idle(); tick();
    chk(tag, 1'b1, e);
    tick(); tick();
  endtask

  task automatic run_burst(input logic [1:0] s, input logic ilv, input string tag);
    logic [1:0] lo;
    order_ilv_i = ilv;
    drive_read({8'h08, s}); tick();               // address 0x020 | s
    for (int j = 1; j <= 4; j++) begin
      drive_cont(1'b0); tick();
      lo = ilv ? (s ^ 2'(j - 1)) : 2'(s + 2'(j - 1));
      chk(tag, 1'b1, 18'h01020 + 18'(lo));
    end
    set_idle(); tick();
    lo = ilv ? s : 2'(s + 2'd0);                  // beat 4 wraps to the start
    chk(tag, 1'b1, 18'h01020 + 18'(lo));
    tick(); tick();
    order_ilv_i = 1'b0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got run still active, expected finish");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; addr_i = '0; wdata_i = '0;
    reg_out_i = 1'b0; order_ilv_i = 1'b0; out_en_n = 1'b0;
    set_idle();
    repeat (3) tick();
    rst = 1'b0;
    chk("R13 reset state", 1'b0, 18'h0);
    drive_cont(1'b0); tick(); tick();
    chk("R13 no burst after reset", 1'b0, 18'h0);
    set_idle(); tick(); tick();

    // Vector table: one write-style cycle, then flow-through read-back
    for (int v = 0; v < NV; v++) begin
      ce_n = 1'b0; addr_i = VECS[v].a; wdata_i = VECS[v].d; advance_n = 1'b1;
      all_we_n = VECS[v].gw_n; lane_mode_n = VECS[v].lm_n; lane_we_n = VECS[v].ln_n;
      start_proc_n = ~VECS[v].proc; start_ctrl_n = VECS[v].proc;
      tick();
      set_idle(); tick(); tick();
      rd_check(VECS[v].a, VECS[v].exp, $sformatf("R1/R8/R9/R10 vector %0d", v));
    end

    // Preload 0x020..0x023 back to back
    for (int i = 0; i < 4; i++) begin
      drive_write(10'h020 + 10'(i), 18'h01020 + 18'(i)); tick();
    end
    set_idle(); tick(); tick();

    run_burst(2'd1, 1'b0, "R2 linear burst");
    run_burst(2'd1, 1'b1, "R3 interleaved burst");
    run_burst(2'd2, 1'b1, "R3 interleaved burst from 2");

    // R4: hold with advance high, then continue
    drive_read(10'h020); tick();
    drive_cont(1'b0); tick(); chk("R4 beat0", 1'b1, 18'h01020);
    drive_cont(1'b1); tick(); chk("R4 beat1", 1'b1, 18'h01021);
    drive_cont(1'b0); tick(); chk("R4 held address", 1'b1, 18'h01021);
    set_idle(); tick(); chk("R4 advance after hold", 1'b1, 18'h01022);
    tick(); tick();

    // R11: a new start every cycle
    drive_read(10'h023); tick();
    drive_read(10'h020); tick(); chk("R11 word 0", 1'b1, 18'h01023);
    drive_read(10'h010); tick(); chk("R11 word 1", 1'b1, 18'h01020);
    set_idle(); tick(); chk("R11 word 2", 1'b1, 18'h3FF11);
    tick(); tick();

    // R5 and R7 in flow-through mode
    drive_read(10'h023); tick(); chk("R5 not before edge k+1", 1'b0, 18'h0);
    set_idle(); tick(); chk("R5 data after edge k+1", 1'b1, 18'h01023);
    tick(); chk("R7 flow hold after deselect", 1'b1, 18'h01023);
    tick(); chk("R7 flow off after second edge", 1'b0, 18'h0);

    // R14: write directly after a read
    drive_read(10'h020); tick();
    drive_write(10'h020, 18'h01020); tick(); chk("R14 preceding read", 1'b1, 18'h01020);
    set_idle(); tick(); chk("R14 write slot off", 1'b0, 18'h0);
    tick(); tick();

    // R12: asynchronous output enable
    drive_read(10'h021); tick();
    set_idle(); tick(); chk("R12 before disable", 1'b1, 18'h01021);
    out_en_n = 1'b1; #1; chk("R12 forced off", 1'b0, 18'h0);
    out_en_n = 1'b0; #1; chk("R12 restored", 1'b1, 18'h01021);
    tick(); tick();

    // R6 and R7 in registered mode
    reg_out_i = 1'b1; tick(); tick();
    drive_read(10'h022); tick();
    set_idle(); tick(); chk("R6 not after edge k+1", 1'b0, 18'h0);
    tick(); chk("R6 data after edge k+2", 1'b1, 18'h01022);
    tick(); chk("R7 registered off", 1'b0, 18'h0);
    reg_out_i = 1'b0; tick(); tick();

    report();
    $finish;
  end
endmodule